// File: doc/BRIEF.md
# PIO Interface-CRC Error Status Responder

This device-side control block follows the Data FIS traffic of a serial ATA PIO command. It decides whether a link CRC failure seen by the link layer is reported back to the host, and it builds the Status and Error bytes for the Device-to-Host register FIS that closes the command. The command layer starts a command with its kind and its expected number of data blocks. The link layer then reports each finished Data FIS, together with a flag that marks a CRC failure on that FIS.

A CRC failure is reported in the same way as a failed DMA transfer. The response carries an error status, the abort bit and, when enabled, the interface-CRC bit, and the command stops at once. There are two cases with no path back to the host, and in those the command ends silently. The first is a failure on the final block of a PIO data-in transfer. The second is a failure on the command packet of a packet command. A command that sees no failure completes with a ready status and a clear error byte.

FIS completion events are a valid-only stream. They cannot be stalled, and events that arrive while no command is open, or after the command has already been decided, are dropped. On the response side the block raises a one-cycle request. It then keeps the Status and Error bytes stable until the transmitter acknowledges them. This acts as the back-pressure point, and no new command is accepted until that acknowledge.

Top module: `pio_crc_status_resp`

## Requirements
- R1: After reset, rsp_req, rsp_status, rsp_error and cmd_busy are all zero.
- R2: When the final data block arrives without a CRC error, rsp_req is high in the cycle after the second clock edge that follows that FIS event. In that cycle rsp_status = 8'h40 (ready, bit 6), rsp_error = 8'h00 and cmd_busy is zero.
- R3: In an error response, rsp_status = 8'h01. Bit 0 (error) is one, and bit 7 (busy), bit 3 (data request) and every other bit are zero.
- R4: In an error response, rsp_error bit 2 (abort) is one and bit 7 (interface CRC) equals cfg_icrc_en. All other bits are zero.
- R5: A CRC error on any data-out block, or on any data-in block other than the last, produces an error response with the R2 timing. The command ends, and the later FIS events of that command are ignored.
- R6: A CRC error on the final data block of a PIO data-in command (cmd_kind 2'd0) produces no response. cmd_busy drops after the next clock edge.
- R7: For a packet command (cmd_kind 2'd2) the first FIS is the command packet. A CRC error on it produces no response and ends the command. Later data blocks are treated as data-out blocks.
- R8: The error state of a command is cleared at the start of the next one, so that a clean command after a failed one completes normally.
- R9: rsp_req lasts exactly one cycle. rsp_status and rsp_error keep their values until rsp_ack is sampled high, and both read zero after that edge.
- R10: cmd_start is ignored while a command is open or a response waits for rsp_ack.
- R11: The last block is the one at which the count of data blocks reaches blk_total. A blk_total of zero behaves as one.
- R12: FIS events that arrive while no command is open cause no response and do not open a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse for a new command |
| cmd_kind | input | 2 | 0 PIO data-in, 1 PIO data-out, 2 packet, 3 handled as data-out |
| blk_total | input | CNT_W | Expected number of data blocks |
| cfg_icrc_en | input | 1 | Sets the interface-CRC bit in error responses |
| fis_end | input | 1 | Valid: one Data FIS has completed |
| fis_crc_err | input | 1 | The completing FIS failed its CRC |
| rsp_ack | input | 1 | Transmitter has taken the response values |
| rsp_req | output | 1 | One-cycle request to send the register FIS |
| rsp_status | output | 8 | Status byte for the FIS |
| rsp_error | output | 8 | Error byte for the FIS |
| cmd_busy | output | 1 | A command is open |

## Verification
The end of the last block and a CRC error can arrive on the same FIS. The bench provokes this by placing the error index on the final block, once for a data-out command and once for a data-in command. The data-out case must give the error response with abort and, with the bit enabled or disabled, interface CRC. The data-in case must give no response at all. For every accepted response the bench also checks that a cmd_start arriving while the response is still unacknowledged leaves the block idle.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

  typedef enum logic [1:0] {
    KIND_PIO_IN  = 2'd0,
    KIND_PIO_OUT = 2'd1,
    KIND_PACKET  = 2'd2,
    KIND_RSVD    = 2'd3
  } cmd_kind_e;

  localparam int ST_ERR_BIT  = 0;
  localparam int ST_DRQ_BIT  = 3;
  localparam int ST_RDY_BIT  = 6;
  localparam int ST_BSY_BIT  = 7;
  localparam int ER_ABRT_BIT = 2;
  localparam int ER_ICRC_BIT = 7;

  function automatic logic [7:0] make_status(input logic failed);
    logic [7:0] s;
    s = 8'h00;
    if (failed) s[ST_ERR_BIT] = 1'b1;
    else        s[ST_RDY_BIT] = 1'b1;
    s[ST_BSY_BIT] = 1'b0;
    s[ST_DRQ_BIT] = 1'b0;
    return s;
  endfunction

  function automatic logic [7:0] make_error(input logic failed, input logic icrc_on);
    logic [7:0] e;
    e = 8'h00;
    if (failed) begin
      e[ER_ABRT_BIT] = 1'b1;
      e[ER_ICRC_BIT] = icrc_on;
    end
    return e;
  endfunction

endpackage

// File: rtl/pcsr_cmd_track.sv
module pcsr_cmd_track
  import pcsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  cmd_kind_e        kind_in,
  input  logic [CNT_W-1:0] total_in,
  input  logic             data_step,
  input  logic             pkt_step,
  input  logic             end_cmd,
  output logic             busy,
  output cmd_kind_e        kind_q,
  output logic             in_pkt,
  output logic             is_last
);
  localparam int CW = CNT_W + 1;

  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_q  <= KIND_PIO_IN;
      total_q <= '0;
      cnt_q   <= '0;
      in_pkt  <= 1'b0;
    end else if (start_ok) begin
      busy    <= 1'b1;
      kind_q  <= kind_in;
      total_q <= total_in;
      cnt_q   <= '0;
      in_pkt  <= (kind_in == KIND_PACKET);
    end else begin
      if (end_cmd)   busy   <= 1'b0;
      if (pkt_step)  in_pkt <= 1'b0;
      if (data_step) cnt_q  <= cnt_q + 1'b1;
    end
  end

  // block being finished is the last one once the running count reaches the total
  assign is_last = (CW'(cnt_q) + CW'(1)) >= CW'(total_q);

endmodule

// File: rtl/pcsr_crc_judge.sv
module pcsr_crc_judge
  import pcsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_ok,
  input  logic      busy,
  input  logic      fis_end,
  input  logic      fis_crc_err,
  input  cmd_kind_e kind_q,
  input  logic      in_pkt,
  input  logic      is_last,
  output logic      data_step,
  output logic      pkt_step,
  output logic      quiet_end,
  output logic      fire_err,
  output logic      fire_ok
);
  logic crc_sticky;
  logic done_ok;
  logic accept;
  logic bad;
  logic no_path;
  logic raise;
  logic good_last;

  always_comb begin
    accept    = busy & fis_end & ~crc_sticky & ~done_ok;
    pkt_step  = accept & in_pkt & ~fis_crc_err;
    data_step = accept & ~in_pkt;
    bad       = accept & fis_crc_err;
    // no return path: command packet, or final block of a device-to-host transfer
    no_path   = in_pkt | ((kind_q == KIND_PIO_IN) & is_last);
    quiet_end = bad & no_path;
    raise     = bad & ~no_path;
    good_last = data_step & ~fis_crc_err & is_last;
    fire_err  = busy & crc_sticky;
    fire_ok   = busy & done_ok & ~crc_sticky;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_sticky <= 1'b0;
      done_ok    <= 1'b0;
    end else if (start_ok) begin
      crc_sticky <= 1'b0;
      done_ok    <= 1'b0;
    end else begin
      if (raise)     crc_sticky <= 1'b1;
      if (good_last) done_ok    <= 1'b1;
    end
  end

endmodule

// File: rtl/pcsr_rsp_hold.sv
module pcsr_rsp_hold
  import pcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_err,
  input  logic       fire_ok,
  input  logic       icrc_en,
  input  logic       ack,
  output logic       req,
  output logic [7:0] status,
  output logic [7:0] error,
  output logic       pend
);
  logic fire;

  assign fire = fire_err | fire_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      pend   <= 1'b0;
      status <= 8'h00;
      error  <= 8'h00;
    end else begin
      req <= fire;
      if (fire) begin
        pend   <= 1'b1;
        status <= make_status(fire_err);
        error  <= make_error(fire_err, icrc_en);
      end else if (pend && ack) begin
        pend   <= 1'b0;
        status <= 8'h00;
        error  <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/pio_crc_status_resp.sv
module pio_crc_status_resp
  import pcsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_kind,
  input  logic [CNT_W-1:0] blk_total,
  input  logic             cfg_icrc_en,
  input  logic             fis_end,
  input  logic             fis_crc_err,
  input  logic             rsp_ack,
  output logic             rsp_req,
  output logic [7:0]       rsp_status,
  output logic [7:0]       rsp_error,
  output logic             cmd_busy
);
  logic      start_ok;
  logic      rsp_pend;
  logic      data_step;
  logic      pkt_step;
  logic      quiet_end;
  logic      fire_err;
  logic      fire_ok;
  logic      end_cmd;
  logic      in_pkt;
  logic      is_last;
  cmd_kind_e kind_q;

  assign start_ok = cmd_start & ~cmd_busy & ~rsp_pend;
  assign end_cmd  = fire_err | fire_ok | quiet_end;

  pcsr_cmd_track #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .kind_in   (cmd_kind_e'(cmd_kind)),
    .total_in  (blk_total),
    .data_step (data_step),
    .pkt_step  (pkt_step),
    .end_cmd   (end_cmd),
    .busy      (cmd_busy),
    .kind_q    (kind_q),
    .in_pkt    (in_pkt),
    .is_last   (is_last)
  );

  pcsr_crc_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ok    (start_ok),
    .busy        (cmd_busy),
    .fis_end     (fis_end),
    .fis_crc_err (fis_crc_err),
    .kind_q      (kind_q),
    .in_pkt      (in_pkt),
    .is_last     (is_last),
    .data_step   (data_step),
    .pkt_step    (pkt_step),
    .quiet_end   (quiet_end),
    .fire_err    (fire_err),
    .fire_ok     (fire_ok)
  );

  pcsr_rsp_hold u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_err (fire_err),
    .fire_ok  (fire_ok),
    .icrc_en  (cfg_icrc_en),
    .ack      (rsp_ack),
    .req      (rsp_req),
    .status   (rsp_status),
    .error    (rsp_error),
    .pend     (rsp_pend)
  );

endmodule

// File: rtl/pcsr_checker.sv
module pcsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       rsp_ack,
  input logic       rsp_req,
  input logic [7:0] rsp_status,
  input logic [7:0] rsp_error,
  input logic       cmd_busy,
  input logic       rsp_pend
);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_req |=> !rsp_req); // R9

  AST_HOLD_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pend && !rsp_ack && !rsp_req) |=> ($stable(rsp_status) && $stable(rsp_error))); // R9

  AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pend && rsp_ack) |=> (rsp_status == 8'h00 && rsp_error == 8'h00)); // R9

  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_req && rsp_status[0]) |-> (rsp_status == 8'h01)); // R3

  AST_ERR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_req && rsp_status[0]) |-> (rsp_error[2] && ((rsp_error & 8'h7B) == 8'h00))); // R4

  AST_OK_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_req && !rsp_status[0]) |-> (rsp_status == 8'h40 && rsp_error == 8'h00)); // R2

  AST_IDLE_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_req |-> !cmd_busy); // R2

  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pend && cmd_start) |=> !cmd_busy); // R10

endmodule

bind pio_crc_status_resp pcsr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .rsp_ack    (rsp_ack),
  .rsp_req    (rsp_req),
  .rsp_status (rsp_status),
  .rsp_error  (rsp_error),
  .cmd_busy   (cmd_busy),
  .rsp_pend   (rsp_pend)
);

// File: tb/pio_crc_status_resp_tb.sv
module pio_crc_status_resp_tb;
  localparam int CNT_W = 8;
  localparam int NVEC  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_start = 1'b0;
  logic [1:0]       cmd_kind = 2'd0;
  logic [CNT_W-1:0] blk_total = '0;
  logic             cfg_icrc_en = 1'b1;
  logic             fis_end = 1'b0;
  logic             fis_crc_err = 1'b0;
  logic             rsp_ack = 1'b0;
  logic             rsp_req;
  logic [7:0]       rsp_status;
  logic [7:0]       rsp_error;
  logic             cmd_busy;

  int checks = 0;
  int failures = 0;
  int req_cnt = 0;
  bit req_wide = 0;
  bit req_prev = 0;
  logic [7:0] cap_st = 8'h00;
  logic [7:0] cap_er = 8'h00;

  always #5 clk = ~clk;

  pio_crc_status_resp #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .blk_total(blk_total), .cfg_icrc_en(cfg_icrc_en), .fis_end(fis_end),
    .fis_crc_err(fis_crc_err), .rsp_ack(rsp_ack), .rsp_req(rsp_req),
    .rsp_status(rsp_status), .rsp_error(rsp_error), .cmd_busy(cmd_busy)
  );

  // {kind[43:42], icrc[41], exp_rsp[40], total[39:32], nfis[31:24], err_idx[23:16], st[15:8], er[7:0]}
  localparam logic [43:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b1, 8'd3, 8'd3, 8'hFF, 8'h40, 8'h00},
    {2'd1, 1'b1, 1'b1, 8'd4, 8'd4, 8'd1,  8'h01, 8'h84},
    {2'd1, 1'b0, 1'b1, 8'd2, 8'd2, 8'd1,  8'h01, 8'h04},
    {2'd1, 1'b1, 1'b1, 8'd2, 8'd2, 8'hFF, 8'h40, 8'h00},
    {2'd0, 1'b1, 1'b1, 8'd3, 8'd3, 8'd0,  8'h01, 8'h84},
    {2'd0, 1'b1, 1'b0, 8'd3, 8'd3, 8'd2,  8'h00, 8'h00},
    {2'd2, 1'b1, 1'b0, 8'd2, 8'd3, 8'd0,  8'h00, 8'h00},
    {2'd2, 1'b1, 1'b1, 8'd2, 8'd3, 8'd2,  8'h01, 8'h84},
    {2'd2, 1'b1, 1'b1, 8'd1, 8'd2, 8'hFF, 8'h40, 8'h00},
    {2'd1, 1'b1, 1'b1, 8'd0, 8'd2, 8'hFF, 8'h40, 8'h00},
    {2'd0, 1'b1, 1'b0, 8'd1, 8'd1, 8'd0,  8'h00, 8'h00},
    {2'd0, 1'b1, 1'b0, 8'd0, 8'd1, 8'd0,  8'h00, 8'h00}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2 clean data-in";
      1: return "R5 R3 R4 data-out mid-block error";
      2: return "R4 data-out last-block error icrc off";
      3: return "R8 clean after failed command";
      4: return "R5 data-in first-block error";
      5: return "R6 data-in last-block error";
      6: return "R7 packet error";
      7: return "R7 packet data-block error";
      8: return "R7 clean packet";
      9: return "R11 zero total data-out";
      10: return "R11 R6 single block data-in error";
      default: return "R11 zero total data-in error";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rsp_req) begin
      req_cnt++;
      cap_st = rsp_status;
      cap_er = rsp_error;
      if (req_prev) req_wide = 1;
    end
    req_prev = rsp_req;
  endtask

  task automatic clear_mon();
    req_cnt = 0; req_wide = 0; req_prev = 0; cap_st = 8'h00; cap_er = 8'h00;
  endtask

  task automatic start_cmd(input logic [1:0] k, input logic [7:0] tot, input logic icrc);
    tick();
    cmd_kind = k; blk_total = tot; cfg_icrc_en = icrc; cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0;
  endtask

  task automatic send_fis(input bit err);
    tick();
    fis_end = 1'b1; fis_crc_err = err;
    tick();
    fis_end = 1'b0; fis_crc_err = 1'b0;
  endtask

  task automatic ack_and_check(input string tag, input logic [7:0] est, input logic [7:0] eer);
    repeat (4) tick();
    check(rsp_status == est && rsp_error == eer, {tag, " R9 held until ack"},
          {rsp_status, rsp_error}, {est, eer});
    cmd_start = 1'b1; cmd_kind = 2'd1; blk_total = 8'd5;
    tick();
    cmd_start = 1'b0;
    tick();
    check(cmd_busy == 1'b0, {tag, " R10 start ignored while pending"}, cmd_busy, 0);
    rsp_ack = 1'b1;
    tick();
    rsp_ack = 1'b0;
    tick();
    check(rsp_status == 8'h00 && rsp_error == 8'h00, {tag, " R9 cleared after ack"},
          {rsp_status, rsp_error}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check(rsp_req == 0 && rsp_status == 0 && rsp_error == 0 && cmd_busy == 0,
          "R1 reset outputs", {rsp_req, rsp_status, rsp_error, cmd_busy}, 0);
    rst_n = 1'b1;
    tick();

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [43:0] v;
      v = VEC[i];
      clear_mon();
      start_cmd(v[43:42], v[39:32], v[41]);
      for (int f = 0; f < int'(v[31:24]); f++) send_fis(f == int'(v[23:16]));
      repeat (6) tick();
      check(req_cnt == int'(v[40]), {vec_tag(i), " response count"}, req_cnt, int'(v[40]));
      check(cmd_busy == 1'b0, {vec_tag(i), " command ended"}, cmd_busy, 0);
      if (v[40]) begin
        check(cap_st == v[15:8], {vec_tag(i), " status"}, cap_st, v[15:8]);
        check(cap_er == v[7:0], {vec_tag(i), " error"}, cap_er, v[7:0]);
        check(!req_wide, {vec_tag(i), " R9 single-cycle request"}, req_wide, 0);
        ack_and_check(vec_tag(i), v[15:8], v[7:0]);
      end
    end

    // R2 exact timing: request in the cycle after the second edge following the FIS
    clear_mon();
    start_cmd(2'd1, 8'd1, 1'b1);
    tick();
    fis_end = 1'b1;
    tick();                       // edge 1 passes before this sample
    fis_end = 1'b0;
    check(rsp_req == 1'b0, "R2 no request after first edge", rsp_req, 0);
    tick();                       // edge 2
    check(rsp_req == 1'b1 && cmd_busy == 1'b0, "R2 request after second edge",
          {rsp_req, cmd_busy}, 2'b10);
    ack_and_check("R2 timing", 8'h40, 8'h00);

    // R5 blocks after a reported error are ignored: no second response
    clear_mon();
    start_cmd(2'd1, 8'd3, 1'b1);
    tick(); fis_end = 1'b1; fis_crc_err = 1'b1;
    tick(); fis_end = 1'b1; fis_crc_err = 1'b0;
    tick(); fis_end = 1'b1;
    tick(); fis_end = 1'b0;
    repeat (4) tick();
    check(req_cnt == 1 && cap_st == 8'h01, "R5 back-to-back blocks after error",
          {req_cnt[7:0], cap_st}, 16'h0101);
    ack_and_check("R5 back-to-back", 8'h01, 8'h84);

    // R10 restart while busy is ignored: command still needs three blocks
    clear_mon();
    start_cmd(2'd1, 8'd3, 1'b1);
    start_cmd(2'd0, 8'd1, 1'b1);
    send_fis(0);
    repeat (4) tick();
    check(req_cnt == 0 && cmd_busy == 1'b1, "R10 start while busy ignored",
          {req_cnt[7:0], 7'd0, cmd_busy}, 16'h0001);
    send_fis(0); send_fis(0);
    repeat (4) tick();
    check(req_cnt == 1 && cap_st == 8'h40, "R10 original command completes",
          {req_cnt[7:0], cap_st}, 16'h0140);
    ack_and_check("R10", 8'h40, 8'h00);

    // R12 events while idle
    clear_mon();
    send_fis(1); send_fis(0);
    repeat (4) tick();
    check(req_cnt == 0 && cmd_busy == 1'b0, "R12 idle events ignored",
          {req_cnt[7:0], 7'd0, cmd_busy}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule